// File: doc/BRIEF.md
# Packet Injection Template Engine

The engine keeps a small set of frame templates in an on-chip word memory and, when asked, plays one of them out as a stream of 16-bit words. Software fills the templates through a shared buffer write port. That port also carries traffic for other structures, and only offsets at or above the template region base land in the template memory. Each stored entry is 18 bits wide:

- data bits [15:0] hold the word to transmit;
- bit 16 marks the final word of the template;
- bit 17 asks for the word to be replaced at run time.

A request names a template slot and carries one 16-bit user value. The engine walks the slot word by word. Wherever the replace flag is set, it sends the captured user value instead of the stored data. It closes the frame after the word marked as final, or after the last word of the slot if no word is marked. The output is a valid/ready stream with an end-of-frame marker. Checksum generation and link framing are left to downstream logic.

Top module: `tmpl_inject`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `tx_valid_o` and `busy_o` are 0.
- R2: A write with `cfg_we_i` high and `cfg_off_i` at or above 512 stores `cfg_data_i` at local word `cfg_off_i - 512`. Template n occupies local words n*64 to n*64+63. A word is sent in order within its template, and its bits [15:0] are the output data when bit 17 is 0.
- R3: Writes with `cfg_off_i` below 512 leave the template memory unchanged.
- R4: A request (`req_i` high while `busy_o` is low) is accepted on that clock edge. From the following cycle `tx_valid_o` is high with word 0 of template `req_tpl_i`.
- R5: For a word whose bit 17 is set, `tx_data_o` equals the `req_user_i` value sampled at acceptance.
- R6: `tx_last_o` is high on the word whose bit 16 is set. After that word is taken, `tx_valid_o` and `busy_o` are low on the next cycle.
- R7: If none of a template's 64 words has bit 16 set, the 64th word carries `tx_last_o` and ends the frame.
- R8: `busy_o` stays high for the whole frame, and requests during a frame are ignored.
- R9: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_data_o`, `tx_last_o` and `tx_valid_o` hold, and the engine does not advance.
- R10: Changes on `req_user_i` after acceptance have no effect on the frame in progress.
- R11: A request presented on the first cycle after a frame ends is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Buffer write strobe |
| cfg_off_i | input | 10 | Buffer write offset |
| cfg_data_i | input | 18 | Buffer write value: data, last flag, replace flag |
| req_i | input | 1 | Injection request |
| req_tpl_i | input | 3 | Template index of the request |
| req_user_i | input | 16 | User value for replaced words |
| busy_o | output | 1 | Frame in progress |
| tx_valid_o | output | 1 | Output word valid |
| tx_data_o | output | 16 | Output word |
| tx_last_o | output | 1 | Final word of frame |
| tx_ready_i | input | 1 | Downstream ready |

## Verification
All eight templates are loaded with lengths from one word to a full slot. One slot has an explicit final word in position 63, and another has no final flag at all. Together they separate end-by-flag from end-by-count. Every template is played three ways, each with a fresh user value:

- With ready held high, the bench checks word order and flag handling.
- With ready dropping on every third cycle, the bench checks that the output holds during stalls.
- With ready held high and a competing request held through the frame, the bench checks that a busy engine ignores requests.

A stray write below the region base carries a final flag. It would cut one template short if it leaked into the memory.

// File: rtl/tmpl_inject.sv
module tmpl_inject #(
  parameter int NUM_TPL     = 8,
  parameter int TPL_WORDS   = 64,
  parameter int DW          = 16,
  parameter int OFF_W       = 10,
  parameter int REGION_BASE = 512
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cfg_we_i,
  input  logic [OFF_W-1:0]           cfg_off_i,
  input  logic [DW+1:0]              cfg_data_i,
  input  logic                       req_i,
  input  logic [$clog2(NUM_TPL)-1:0] req_tpl_i,
  input  logic [DW-1:0]              req_user_i,
  output logic                       busy_o,
  output logic                       tx_valid_o,
  output logic [DW-1:0]              tx_data_o,
  output logic                       tx_last_o,
  input  logic                       tx_ready_i
);
  localparam int TW    = $clog2(NUM_TPL);
  localparam int WW    = $clog2(TPL_WORDS);
  localparam int DEPTH = NUM_TPL * TPL_WORDS;
  localparam int AW    = TW + WW;
  localparam int EW    = DW + 2;

  logic [EW-1:0] mem [DEPTH];

  logic [OFF_W-1:0] off_rel;
  logic             wr_en;
  assign off_rel = cfg_off_i - OFF_W'(REGION_BASE);
  assign wr_en   = cfg_we_i && (cfg_off_i >= OFF_W'(REGION_BASE)) && (32'(off_rel) < DEPTH);

  always_ff @(posedge clk_i)
    if (wr_en) mem[off_rel[AW-1:0]] <= cfg_data_i;

  logic          valid_q, last_q;
  logic [DW-1:0] data_q, user_q;
  logic [TW-1:0] tpl_q;
  logic [WW-1:0] word_q;

  logic          accept, fire, load;
  logic [TW-1:0] nxt_tpl;
  logic [WW-1:0] nxt_word;
  logic [DW-1:0] nxt_user;
  logic [EW-1:0] entry;

  assign accept   = req_i && !valid_q;
  assign fire     = valid_q && tx_ready_i;
  assign load     = accept || (fire && !last_q);
  assign nxt_tpl  = accept ? req_tpl_i : tpl_q;
  assign nxt_word = accept ? '0 : word_q + 1'b1;
  assign nxt_user = accept ? req_user_i : user_q;
  assign entry    = mem[{nxt_tpl, nxt_word}];

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      data_q  <= '0;
      user_q  <= '0;
      tpl_q   <= '0;
      word_q  <= '0;
    end else begin
      if (accept)              valid_q <= 1'b1;
      else if (fire && last_q) valid_q <= 1'b0;
      if (load) begin
        tpl_q  <= nxt_tpl;
        word_q <= nxt_word;
        user_q <= nxt_user;
        data_q <= entry[DW+1] ? nxt_user : entry[DW-1:0];
        last_q <= entry[DW] || (nxt_word == WW'(TPL_WORDS - 1));
      end
    end
  end

  assign busy_o     = valid_q;
  assign tx_valid_o = valid_q;
  assign tx_data_o  = data_q;
  assign tx_last_o  = last_q;
endmodule

// File: rtl/tmpl_inject_chk.sv
module tmpl_inject_chk #(
  parameter int TPL_WORDS = 64,
  parameter int DW        = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          busy_o,
  input logic          tx_valid_o,
  input logic [DW-1:0] tx_data_o,
  input logic          tx_last_o,
  input logic          tx_ready_i
);
  localparam int CW = $clog2(TPL_WORDS) + 1;
  logic [CW-1:0] beats;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) beats <= '0;
    else if (req_i && !busy_o) beats <= '0;
    else if (tx_valid_o && tx_ready_i) beats <= beats + 1'b1;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk_i) !rst_ni |=> !tx_valid_o && !busy_o);

  // R4
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !busy_o |=> tx_valid_o);

  // R6
  end_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_ready_i && tx_last_o |=> !tx_valid_o);

  // R8
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !(tx_ready_i && tx_last_o) |=> tx_valid_o && busy_o);

  // R9
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o));

  // R7
  max_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && (32'(beats) == TPL_WORDS - 1) |-> tx_last_o);
endmodule

bind tmpl_inject tmpl_inject_chk #(.TPL_WORDS(TPL_WORDS), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .busy_o(busy_o),
  .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .tx_last_o(tx_last_o),
  .tx_ready_i(tx_ready_i)
);

// File: tb/tmpl_inject_test.sv
`timescale 1ns/1ps
module tmpl_inject_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [9:0]  cfg_off = '0;
  logic [17:0] cfg_data = '0;
  logic        req = 1'b0;
  logic [2:0]  tpl = '0;
  logic [15:0] user = '0;
  logic        ready = 1'b0;
  logic        busy, valid, last;
  logic [15:0] data;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [17:0] exp_mem [512];

  always #2 clk = ~clk;

  tmpl_inject uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_off_i(cfg_off),
    .cfg_data_i(cfg_data), .req_i(req), .req_tpl_i(tpl), .req_user_i(user),
    .busy_o(busy), .tx_valid_o(valid), .tx_data_o(data), .tx_last_o(last),
    .tx_ready_i(ready)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int off, input logic [17:0] d);
    cfg_we = 1'b1; cfg_off = off[9:0]; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic play(input int t, input logic [15:0] uv, input int mode);
    int len = 64;
    int idx = 0;
    int cyc = 0;
    bit stalled = 0;
    logic [15:0] pd = '0;
    logic pl = 1'b0;
    for (int w = 63; w >= 0; w--) if (exp_mem[t*64+w][16]) len = w + 1;
    req = 1'b1; tpl = t[2:0]; user = uv; ready = (mode != 1);
    @(negedge clk);
    req = 1'b0; user = ~uv;
    if (mode == 2) begin req = 1'b1; tpl = 3'((t + 3) % 8); user = 16'h1234; end
    check(valid === 1'b1, "R4", int'(valid), 1);
    while (idx < len && cyc < 400) begin
      logic [17:0] e;
      logic [15:0] ed;
      bit rdy;
      if (stalled) begin
        check(valid === 1'b1 && data === pd && last === pl, "R9", int'(data), int'(pd));
      end
      check(valid === 1'b1 && busy === 1'b1, "R8", int'({valid, busy}), 3);
      rdy = (mode != 1) || (cyc % 3 != 1);
      ready = rdy;
      if (rdy) begin
        e = exp_mem[t*64+idx];
        ed = e[17] ? uv : e[15:0];
        if (t == 2 && idx == 2)
          check(data === ed, "R3", int'(data), int'(ed));
        else if (e[17])
          check(data === ed, "R5/R10", int'(data), int'(ed));
        else
          check(data === ed, "R2", int'(data), int'(ed));
        if (idx == 63 && !e[16])
          check(last === 1'b1, "R7", int'(last), 1);
        else
          check(last === (idx == len - 1), "R6", int'(last), int'(idx == len - 1));
        idx++;
        stalled = 0;
      end else begin
        stalled = 1; pd = data; pl = last;
      end
      cyc++;
      @(negedge clk);
    end
    req = 1'b0;
    check(valid === 1'b0 && busy === 1'b0, "R6 R11", int'({valid, busy}), 0);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(negedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lens [8] = '{1, 2, 5, 17, 33, 50, 64, 64};
    for (int i = 0; i < 512; i++) exp_mem[i] = '0;
    repeat (3) @(negedge clk);
    check(valid === 1'b0 && busy === 1'b0, "R1", int'({valid, busy}), 0);
    rst_n = 1'b1;
    check(valid === 1'b0 && busy === 1'b0, "R1", int'({valid, busy}), 0);
    for (int t = 0; t < 8; t++) begin
      for (int w = 0; w < 64; w++) begin
        logic [17:0] d;
        d[15:0] = 16'((t * 4096) ^ (w * 37) ^ 16'h5a);
        d[16] = (t != 7) && (w == lens[t] - 1);
        d[17] = (w % 5 == 2);
        exp_mem[t*64+w] = d;
        wr(512 + t*64 + w, d);
      end
    end
    wr(130, 18'h1ffff);
    for (int m = 0; m < 3; m++)
      for (int t = 0; t < 8; t++)
        play(t, 16'(16'hc000 + m * 256 + t * 17), m);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule